// File: doc/BRIEF.md
# Two-Output Prioritised Interrupt Controller

This block collects interrupt requests from seventeen sources and presents them to a processor core on two active-high request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). The low six sources come from asynchronous device pins. The upper eleven come from on-chip peripherals that share the controller's clock. For every source, software chooses level or rising-edge detection, enables or masks it, picks which of the two outputs it drives, and gives it a 2-bit priority level. Each output also has its own gate bit.

Software reaches the controller through a single-cycle register port: writes take effect on the clock edge, and reads are combinational on the address. Two read-only identifier registers hold the number of the winning source for each output. A handler reads the identifier, services that source and, for an edge source, writes a 1 to its pending bit to clear it.

Sources 0 to 5 are the pins and sources 6 to 16 are the internal lines (internal line k is source 6+k). Register words, by `reg_addr`:
- 0: detection type, bit i = 1 means edge.
- 1: source enables.
- 2: routing, bit i = 1 means fast output.
- 3: output gates, bit 0 for `irq_o` and bit 1 for `fiq_o`.
- 4: pending; a write clears the bits written as 1.
- 5: status, which is pending AND enable.
- 6: normal-output identifier.
- 7: fast-output identifier.
- 8: priority levels for sources 0 to 15, two bits each, source i at bits 2i+1:2i.
- 9: priority level for source 16 at bits 1:0.

Top module: `prio_intc`

## Requirements
- R1: After reset, words 0 to 5, 8 and 9 read 0, words 6 and 7 read 31, and both outputs are low.
- R2: For a level source, the pending bit equals the source input one clock later. For an internal line, the enabled and gated output therefore rises and falls one clock after the line does.
- R3: Writing 1 to the pending bit of a level source whose input is still high leaves that bit set.
- R4: An edge source sets its pending bit on a rising input and holds it after the input falls. Writing 0 to the bit leaves it set. Writing 1 to it clears it.
- R5: A pin source passes through two synchroniser flops before the pending flop. A pin rising just after one edge shows in the pending bit after the third edge, and not after the second.
- R6: A source whose enable bit is 0 does not appear in status, does not raise an output, and is never reported by an identifier.
- R7: The output gate bits block `irq_o` and `fiq_o`. They do not change status or the identifiers.
- R8: A source with routing bit 1 drives only `fiq_o` and `fiq_id` (word 7). A source with routing bit 0 drives only `irq_o` and word 6.
- R9: Among the enabled pending sources of one output, the highest priority level wins. Priority 3 is the highest and priority 0 the lowest. When levels tie, the lower source number wins.
- R10: An identifier reads 31 when no enabled pending source is routed to its output. An output is high only when its identifier is not 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 6 | Asynchronous pin requests, sources 0 to 5 |
| int_line_i | input | 11 | Synchronous peripheral requests, sources 6 to 16 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Normal interrupt request, active high |
| fiq_o | output | 1 | Fast interrupt request, active high |

## Verification
The hardest case to reach is the edge-mode pending bit after its source pulse has ended, with the output still asserted only by latched state. The directed test gives an internal line a one-cycle pulse, waits several clocks, and then checks that a write of 0 leaves the bit set while a write of 1 clears it. Priority ties also need care. The test raises two equal-level internal lines together, then reprograms the level of the higher-numbered one and of source 16, which sits in the second priority word. This shows that both word decoding and tie-breaking reach the identifier register.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned ID_W    = 5;
  localparam logic [ID_W-1:0] NONE_ID = 5'd31;

  typedef enum logic [ADDR_W-1:0] {
    A_TRIG   = 4'd0,
    A_ENABLE = 4'd1,
    A_ROUTE  = 4'd2,
    A_GATE   = 4'd3,
    A_PEND   = 4'd4,
    A_STAT   = 4'd5,
    A_IRQID  = 4'd6,
    A_FIQID  = 4'd7,
    A_PRIO0  = 4'd8
  } reg_word_e;
endpackage

// File: rtl/prio_intc_sync.sv
module prio_intc_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/prio_intc_pend.sv
module prio_intc_pend #(
  parameter int unsigned N = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] trig_edge,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] pend,
  output logic [N-1:0] rise_evt
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  assign rise_evt = src & ~prev_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend[i] <= 1'b0;
      else if (trig_edge[i]) pend[i] <= rise_evt[i] | (pend[i] & ~clr_req[i]);
      else                   pend[i] <= src[i];
    end
  end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int unsigned N  = 17,
  parameter int unsigned PW = 2
) (
  input  logic [N-1:0]    active,
  input  logic [N*PW-1:0] prio_flat,
  output logic [ID_W-1:0] win_id
);
  // Highest level wins; strict compare in ascending order keeps the lower index on ties.
  function automatic logic [ID_W-1:0] pick(input logic [N-1:0] act,
                                           input logic [N*PW-1:0] pr);
    logic [ID_W-1:0] best;
    logic [PW-1:0]   best_lvl;
    logic            found;
    best = NONE_ID;
    best_lvl = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (act[i] && (!found || pr[i*PW +: PW] > best_lvl)) begin
        found    = 1'b1;
        best     = ID_W'(i);
        best_lvl = pr[i*PW +: PW];
      end
    end
    return best;
  endfunction

  assign win_id = pick(active, prio_flat);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int unsigned N_EXT       = 6,
  parameter int unsigned N_INT       = 11,
  parameter int unsigned PRIO_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic [N_INT-1:0]  int_line_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned N_SRC = N_EXT + N_INT;
  localparam int unsigned FPW   = DATA_W / PRIO_W;
  localparam int unsigned N_PW  = (N_SRC + FPW - 1) / FPW;

  logic [N_EXT-1:0]        ext_sync;
  logic [N_SRC-1:0]        src_vec;
  logic [N_SRC-1:0]        trig_q, en_q, route_q;
  logic [1:0]              gate_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  logic [N_SRC-1:0]        pend_q, rise_evt, clr_req;
  logic [N_SRC-1:0]        irq_act, fiq_act;
  logic [ID_W-1:0]         irq_id, fiq_id;

  prio_intc_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin_i), .q(ext_sync)
  );

  assign src_vec = {int_line_i, ext_sync};

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] w);
    return a == w;
  endfunction

  assign clr_req = (reg_we && hit(reg_addr, A_PEND)) ? reg_wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
      gate_q  <= '0;
    end else if (reg_we) begin
      if (hit(reg_addr, A_TRIG))   trig_q  <= reg_wdata[N_SRC-1:0];
      if (hit(reg_addr, A_ENABLE)) en_q    <= reg_wdata[N_SRC-1:0];
      if (hit(reg_addr, A_ROUTE))  route_q <= reg_wdata[N_SRC-1:0];
      if (hit(reg_addr, A_GATE))   gate_q  <= reg_wdata[1:0];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_prio
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(A_PRIO0 + i / FPW);
    localparam int unsigned       LSB   = (i % FPW) * PRIO_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              prio_q[i*PRIO_W +: PRIO_W] <= '0;
      else if (reg_we && hit(reg_addr, WADDR)) prio_q[i*PRIO_W +: PRIO_W] <= reg_wdata[LSB +: PRIO_W];
    end
  end

  prio_intc_pend #(.N(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src(src_vec), .trig_edge(trig_q),
    .clr_req(clr_req), .pend(pend_q), .rise_evt(rise_evt)
  );

  assign irq_act = pend_q & en_q & ~route_q;
  assign fiq_act = pend_q & en_q & route_q;

  prio_intc_arb #(.N(N_SRC), .PW(PRIO_W)) u_arb_irq (
    .active(irq_act), .prio_flat(prio_q), .win_id(irq_id)
  );
  prio_intc_arb #(.N(N_SRC), .PW(PRIO_W)) u_arb_fiq (
    .active(fiq_act), .prio_flat(prio_q), .win_id(fiq_id)
  );

  assign irq_o = gate_q[0] & (|irq_act);
  assign fiq_o = gate_q[1] & (|fiq_act);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_TRIG:   reg_rdata[N_SRC-1:0] = trig_q;
      A_ENABLE: reg_rdata[N_SRC-1:0] = en_q;
      A_ROUTE:  reg_rdata[N_SRC-1:0] = route_q;
      A_GATE:   reg_rdata[1:0]       = gate_q;
      A_PEND:   reg_rdata[N_SRC-1:0] = pend_q;
      A_STAT:   reg_rdata[N_SRC-1:0] = pend_q & en_q;
      A_IRQID:  reg_rdata[ID_W-1:0]  = irq_id;
      A_FIQID:  reg_rdata[ID_W-1:0]  = fiq_id;
      default: begin
        for (int w = 0; w < N_PW; w++) begin
          if (reg_addr == ADDR_W'(A_PRIO0 + w)) begin
            for (int i = 0; i < N_SRC; i++) begin
              if (i / FPW == w) reg_rdata[(i % FPW) * PRIO_W +: PRIO_W] = prio_q[i*PRIO_W +: PRIO_W];
            end
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
#(
  parameter int unsigned N = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    src,
  input logic [N-1:0]    pend,
  input logic [N-1:0]    trig,
  input logic [N-1:0]    clr,
  input logic [N-1:0]    irq_act,
  input logic [N-1:0]    fiq_act,
  input logic [ID_W-1:0] irq_id,
  input logic [ID_W-1:0] fiq_id,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [1:0]      gate
);
  logic [31:0] irq_act_w, fiq_act_w;
  assign irq_act_w = 32'(irq_act);
  assign fiq_act_w = 32'(fiq_act);

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(trig)) & (pend ^ $past(src))) == '0);

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(pend & trig & ~clr) & ~pend) == '0);

  // R7
  fiq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> gate[1]);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gate[0]);

  // R10
  irq_id_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id != NONE_ID) |-> irq_act_w[irq_id]);

  // R10
  fiq_id_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_id != NONE_ID) |-> fiq_act_w[fiq_id]);

  // R8
  split_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id != NONE_ID) |-> (irq_id != fiq_id));

  // R10
  irq_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_id != NONE_ID));
endmodule

bind prio_intc prio_intc_chk #(.N(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src(src_vec), .pend(pend_q), .trig(trig_q),
  .clr(clr_req), .irq_act(irq_act), .fiq_act(fiq_act), .irq_id(irq_id),
  .fiq_id(fiq_id), .irq_o(irq_o), .fiq_o(fiq_o), .gate(gate_q)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ext_pin_i = '0;
  logic [10:0] int_line_i = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, fiq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i), .int_line_i(int_line_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ext_pin_i = '0; int_line_i = '0; reg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk("R1 reset word", v, (a == 6 || a == 7) ? 32'd31 : 32'd0);
    end
    chk("R1 irq_o low", {31'd0, irq_o}, 0);
    chk("R1 fiq_o low", {31'd0, fiq_o}, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    wr(4'd1, 32'h100);
    wr(4'd3, 32'h1);
    int_line_i[2] = 1'b1;
    @(negedge clk);
    chk("R2 level rise", {31'd0, irq_o}, 1);
    rd(4'd6, v);
    chk("R2 irq id", v, 8);
    wr(4'd4, 32'h100);
    rd(4'd4, v);
    chk("R3 level clear ignored", v, 32'h100);
    int_line_i[2] = 1'b0;
    @(negedge clk);
    chk("R2 level fall", {31'd0, irq_o}, 0);
    rd(4'd4, v);
    chk("R2 pending follows", v, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    do_reset();
    wr(4'd0, 32'h80);
    wr(4'd1, 32'h80);
    wr(4'd3, 32'h1);
    int_line_i[1] = 1'b1;
    @(negedge clk);
    int_line_i[1] = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd4, v);
    chk("R4 edge latched", v, 32'h80);
    chk("R4 irq held", {31'd0, irq_o}, 1);
    wr(4'd4, 32'h0);
    rd(4'd4, v);
    chk("R4 write zero keeps", v, 32'h80);
    wr(4'd4, 32'h80);
    rd(4'd4, v);
    chk("R4 write one clears", v, 0);
    chk("R4 irq dropped", {31'd0, irq_o}, 0);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    do_reset();
    @(negedge clk);
    ext_pin_i[0] = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd4, v);
    chk("R5 not after two edges", v & 32'h1, 0);
    @(negedge clk);
    rd(4'd4, v);
    chk("R5 after three edges", v & 32'h1, 1);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    do_reset();
    wr(4'd3, 32'h1);
    int_line_i[0] = 1'b1;
    @(negedge clk);
    rd(4'd4, v);
    chk("R6 pending while masked", v, 32'h40);
    rd(4'd5, v);
    chk("R6 status masked", v, 0);
    chk("R6 irq masked", {31'd0, irq_o}, 0);
    rd(4'd6, v);
    chk("R6 id masked", v, 31);
    wr(4'd3, 32'h0);
    wr(4'd1, 32'h40);
    rd(4'd5, v);
    chk("R7 status ungated", v, 32'h40);
    chk("R7 irq gated", {31'd0, irq_o}, 0);
    rd(4'd6, v);
    chk("R7 id ungated", v, 6);
    wr(4'd3, 32'h1);
    chk("R7 irq opened", {31'd0, irq_o}, 1);
  endtask

  task automatic t_route();
    logic [31:0] v;
    do_reset();
    wr(4'd1, 32'h40);
    wr(4'd2, 32'h40);
    wr(4'd3, 32'h3);
    int_line_i[0] = 1'b1;
    @(negedge clk);
    chk("R8 fiq high", {31'd0, fiq_o}, 1);
    chk("R8 irq low", {31'd0, irq_o}, 0);
    rd(4'd7, v);
    chk("R8 fiq id", v, 6);
    rd(4'd6, v);
    chk("R10 irq id none", v, 31);
    wr(4'd3, 32'h1);
    chk("R7 fiq gated", {31'd0, fiq_o}, 0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    do_reset();
    wr(4'd1, 32'h10A00);
    wr(4'd3, 32'h1);
    int_line_i[3] = 1'b1;
    int_line_i[5] = 1'b1;
    @(negedge clk);
    rd(4'd6, v);
    chk("R9 tie lower wins", v, 9);
    wr(4'd8, 32'h2 << 22);
    rd(4'd6, v);
    chk("R9 higher level wins", v, 11);
    int_line_i[10] = 1'b1;
    wr(4'd9, 32'h3);
    rd(4'd6, v);
    chk("R9 second word level", v, 16);
    rd(4'd9, v);
    chk("R9 prio readback", v, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_sync();
    t_mask();
    t_route();
    t_prio();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule